// File: doc/BRIEF.md
# Serial Test Access Port Controller

This block is the serial test port of a chip. A 16-state controller advances on each rising edge of the test clock, steered by the mode-select input. It routes the serial data input to the serial data output through one of three paths: a 4-bit instruction register, a one-bit bypass stage, or a 32-bit identification register. When a boundary instruction is active, the path goes through an external boundary-scan chain. The decoder recognises four instructions: identification readout, bypass, sample/preload and external test.

For the boundary-scan chain, the block produces capture, shift and update strobes and a drive-mode select. It takes the chain's serial output back and places it on the test data output. The test data output changes only on falling clock edges. Its enable is high only while a shift state is active, and the pad buffer uses this enable to tri-state the pin. The chain cells themselves are not part of this block.

Top module: `scan_port`

## Requirements
- R1: The controller follows the standard 16-state test port graph, taking the mode-select value at each rising edge of `testClk`.
- R2: Five consecutive rising edges with `testModeSel` high place the controller in Test-Logic-Reset from any state.
- R3: `testResetN` low resets the controller asynchronously, disables the output at once, and makes the identification instruction active.
- R4: `testDataOutEn` is high only in Shift-IR and Shift-DR. `testDataOut` and `testDataOutEn` change only on falling edges of `testClk`.
- R5: The instruction register is 4 bits wide and shifts least significant bit first. Capture-IR loads 0001, so the first bit read out is 1.
- R6: Instruction codes are 0000 for external test, 0001 for sample/preload, 0010 for identification and 1111 for bypass. A new code takes effect on the falling edge of `testClk` in Update-IR.
- R7: Under the identification instruction, Capture-DR loads the full 32-bit `ID_VALUE` with bit 0 forced to 1. The value shifts out least significant bit first, and every capture reloads it.
- R8: Bypass and every unused code (0011 to 1110) select a one-bit stage. Capture-DR loads 0 into this stage, so the data output is the input delayed by one shift.
- R9: Under sample/preload or external test, `chainCapture`, `chainShift` and `chainUpdate` are high in Capture-DR, Shift-DR and Update-DR respectively. During Shift-DR, `testDataOut` carries `chainSo`.
- R10: `chainDrive` is high exactly when external test (0000) is the active instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| testClk | input | 1 | Test clock |
| testResetN | input | 1 | Asynchronous active-low test reset |
| testModeSel | input | 1 | Mode select, taken on rising edges |
| testDataIn | input | 1 | Serial data in, taken on rising edges |
| testDataOut | output | 1 | Serial data out, updated on falling edges |
| testDataOutEn | output | 1 | Output enable for the data-out pad |
| chainCapture | output | 1 | Boundary chain capture strobe |
| chainShift | output | 1 | Boundary chain shift strobe |
| chainUpdate | output | 1 | Boundary chain update strobe |
| chainDrive | output | 1 | Boundary cells drive the pins (external test) |
| chainSo | input | 1 | Serial output of the boundary chain |

## Verification
The test clock has a period of 4 ns. Inputs are driven 1 ns after each falling edge and are taken on the next rising edge. State, shift registers and chain strobes change at that rising edge. The data output and its enable follow at the next falling edge, so the bench reads them 1 ns after that falling edge, half a cycle after the state moved. An instruction change is checked twice in the same Update-IR cycle: once between the rising and falling edge, where the old decode must still hold, and once after the falling edge, where the new decode must be in place. The asynchronous reset is checked 1 ns after it falls, without waiting for any edge.

// File: rtl/scan_pkg.sv
`timescale 1ns/1ps
package scan_pkg;
  localparam int IR_W = 4;
  localparam logic [IR_W-1:0] IR_CAPTURE  = 4'b0001;
  localparam logic [IR_W-1:0] OP_EXTEST   = 4'b0000;
  localparam logic [IR_W-1:0] OP_SAMPLE   = 4'b0001;
  localparam logic [IR_W-1:0] OP_IDENT    = 4'b0010;
  localparam logic [IR_W-1:0] OP_BYPASS   = 4'b1111;

  typedef enum logic [3:0] {
    stReset     = 4'hF, stIdle      = 4'hC,
    stSelectDr  = 4'h7, stCaptureDr = 4'h6, stShiftDr  = 4'h2, stExit1Dr  = 4'h1,
    stPauseDr   = 4'h3, stExit2Dr   = 4'h0, stUpdateDr = 4'h5,
    stSelectIr  = 4'h4, stCaptureIr = 4'hE, stShiftIr  = 4'hA, stExit1Ir  = 4'h9,
    stPauseIr   = 4'hB, stExit2Ir   = 4'h8, stUpdateIr = 4'hD
  } tapState_t;

  typedef struct packed {
    logic testReset;
    logic captureIr;
    logic shiftIr;
    logic updateIr;
    logic captureDr;
    logic shiftDr;
    logic updateDr;
  } tapStrobes_t;

  typedef enum logic [1:0] {pathBypass, pathIdent, pathChain} drPath_t;
endpackage

// File: rtl/scan_fsm.sv
`timescale 1ns/1ps
module scan_fsm
  import scan_pkg::*;
(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tms,
  output tapState_t   state,
  output tapStrobes_t strobes
);
  tapState_t nextState;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN) state <= stReset;
    else        state <= nextState;
  end

  always_comb begin
    nextState = state;
    unique case (state)
      stReset:     nextState = tms ? stReset    : stIdle;
      stIdle:      nextState = tms ? stSelectDr : stIdle;
      stSelectDr:  nextState = tms ? stSelectIr : stCaptureDr;
      stCaptureDr: nextState = tms ? stExit1Dr  : stShiftDr;
      stShiftDr:   nextState = tms ? stExit1Dr  : stShiftDr;
      stExit1Dr:   nextState = tms ? stUpdateDr : stPauseDr;
      stPauseDr:   nextState = tms ? stExit2Dr  : stPauseDr;
      stExit2Dr:   nextState = tms ? stUpdateDr : stShiftDr;
      stUpdateDr:  nextState = tms ? stSelectDr : stIdle;
      stSelectIr:  nextState = tms ? stReset    : stCaptureIr;
      stCaptureIr: nextState = tms ? stExit1Ir  : stShiftIr;
      stShiftIr:   nextState = tms ? stExit1Ir  : stShiftIr;
      stExit1Ir:   nextState = tms ? stUpdateIr : stPauseIr;
      stPauseIr:   nextState = tms ? stExit2Ir  : stPauseIr;
      stExit2Ir:   nextState = tms ? stUpdateIr : stShiftIr;
      stUpdateIr:  nextState = tms ? stSelectDr : stIdle;
      default:     nextState = stReset;
    endcase
  end

  always_comb begin
    strobes.testReset = (state == stReset);
    strobes.captureIr = (state == stCaptureIr);
    strobes.shiftIr   = (state == stShiftIr);
    strobes.updateIr  = (state == stUpdateIr);
    strobes.captureDr = (state == stCaptureDr);
    strobes.shiftDr   = (state == stShiftDr);
    strobes.updateDr  = (state == stUpdateDr);
  end
endmodule

// File: rtl/scan_datapath.sv
`timescale 1ns/1ps
module scan_datapath
  import scan_pkg::*;
#(
  parameter int          ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4D3C_2A15
)(
  input  logic        tck,
  input  logic        trstN,
  input  logic        tdi,
  input  tapStrobes_t strobes,
  input  logic        chainSo,
  output logic        tdo,
  output logic        tdoEn,
  output logic        chainCapture,
  output logic        chainShift,
  output logic        chainUpdate,
  output logic        chainDrive
);
  localparam logic [ID_W-1:0] ID_WORD = {ID_VALUE[ID_W-1:1], 1'b1};

  logic [IR_W-1:0] irShift;
  logic [IR_W-1:0] irActive;
  logic [ID_W-1:0] idShift;
  logic            bypassBit;
  drPath_t         path;
  logic            serialBit;

  // instruction shift stage, rising edge
  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                 irShift <= IR_CAPTURE;
    else if (strobes.captureIr) irShift <= IR_CAPTURE;
    else if (strobes.shiftIr)   irShift <= {tdi, irShift[IR_W-1:1]};
  end

  // active instruction, falling edge
  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN)                 irActive <= OP_IDENT;
    else if (strobes.testReset) irActive <= OP_IDENT;
    else if (strobes.updateIr)  irActive <= irShift;
  end

  always_comb begin
    unique case (irActive)
      OP_IDENT:             path = pathIdent;
      OP_SAMPLE, OP_EXTEST: path = pathChain;
      default:              path = pathBypass;
    endcase
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                                        bypassBit <= 1'b0;
    else if (strobes.captureDr)                        bypassBit <= 1'b0;
    else if (strobes.shiftDr && path == pathBypass)    bypassBit <= tdi;
  end

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                                     idShift <= ID_WORD;
    else if (strobes.captureDr)                     idShift <= ID_WORD;
    else if (strobes.shiftDr && path == pathIdent)  idShift <= {tdi, idShift[ID_W-1:1]};
  end

  always_comb begin
    if (strobes.shiftIr) serialBit = irShift[0];
    else begin
      unique case (path)
        pathIdent: serialBit = idShift[0];
        pathChain: serialBit = chainSo;
        default:   serialBit = bypassBit;
      endcase
    end
  end

  always_ff @(negedge tck or negedge trstN) begin
    if (!trstN) begin
      tdo   <= 1'b0;
      tdoEn <= 1'b0;
    end else begin
      tdo   <= serialBit;
      tdoEn <= strobes.shiftIr | strobes.shiftDr;
    end
  end

  assign chainCapture = strobes.captureDr && path == pathChain;
  assign chainShift   = strobes.shiftDr   && path == pathChain;
  assign chainUpdate  = strobes.updateDr  && path == pathChain;
  assign chainDrive   = (irActive == OP_EXTEST);
endmodule

// File: rtl/scan_port.sv
`timescale 1ns/1ps
module scan_port
  import scan_pkg::*;
#(
  parameter int              ID_W     = 32,
  parameter logic [ID_W-1:0] ID_VALUE = 32'h4D3C_2A15
)(
  input  logic testClk,
  input  logic testResetN,
  input  logic testModeSel,
  input  logic testDataIn,
  output logic testDataOut,
  output logic testDataOutEn,
  output logic chainCapture,
  output logic chainShift,
  output logic chainUpdate,
  output logic chainDrive,
  input  logic chainSo
);
  tapState_t   tapState;
  tapStrobes_t tapStrobes;

  scan_fsm ctrl (
    .tck(testClk), .trstN(testResetN), .tms(testModeSel),
    .state(tapState), .strobes(tapStrobes)
  );

  scan_datapath #(.ID_W(ID_W), .ID_VALUE(ID_VALUE)) dp (
    .tck(testClk), .trstN(testResetN), .tdi(testDataIn),
    .strobes(tapStrobes), .chainSo(chainSo),
    .tdo(testDataOut), .tdoEn(testDataOutEn),
    .chainCapture(chainCapture), .chainShift(chainShift),
    .chainUpdate(chainUpdate), .chainDrive(chainDrive)
  );
endmodule

// File: rtl/scan_port_chk.sv
`timescale 1ns/1ps
module scan_port_chk
  import scan_pkg::*;
(
  input logic      tck,
  input logic      trstN,
  input logic      tms,
  input logic      tdoEn,
  input logic      chainCapture,
  input logic      chainShift,
  input logic      chainDrive,
  input tapState_t state
);
  logic [2:0] highCnt;

  always_ff @(posedge tck or negedge trstN) begin
    if (!trstN)                highCnt <= 3'd0;
    else if (!tms)             highCnt <= 3'd0;
    else if (highCnt != 3'd5)  highCnt <= highCnt + 3'd1;
  end

  assert_five_high_R2: assert property (@(posedge tck) disable iff (!trstN)
    (highCnt == 3'd5) |-> (state == stReset));

  assert_enable_shift_R4: assert property (@(posedge tck) disable iff (!trstN)
    tdoEn |-> (state == stShiftDr || state == stShiftIr));

  assert_chain_shift_R9: assert property (@(posedge tck) disable iff (!trstN)
    chainShift |-> (state == stShiftDr));

  assert_chain_capture_R9: assert property (@(posedge tck) disable iff (!trstN)
    chainCapture |-> (state == stCaptureDr));

  assert_reset_drive_R10: assert property (@(posedge tck) disable iff (!trstN)
    (state == stReset) |=> !chainDrive);
endmodule

bind scan_port scan_port_chk chk (
  .tck(testClk), .trstN(testResetN), .tms(testModeSel), .tdoEn(testDataOutEn),
  .chainCapture(chainCapture), .chainShift(chainShift),
  .chainDrive(chainDrive), .state(tapState)
);

// File: tb/scan_port_test.sv
`timescale 1ns/1ps
module scan_port_test;
  localparam logic [31:0] EXP_ID = 32'h4D3C_2A15;
  localparam int CH_W = 6;

  logic clk = 1'b0;
  logic trstN = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic tdo, tdoEn, cCap, cShift, cUpd, cDrive, cSo;
  logic [CH_W-1:0] chainReg = '0;
  logic [CH_W-1:0] pinPattern = 6'b101101;
  int   updCount = 0;
  int   checks = 0, fails = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  scan_port uut (
    .testClk(clk), .testResetN(trstN), .testModeSel(tms), .testDataIn(tdi),
    .testDataOut(tdo), .testDataOutEn(tdoEn), .chainCapture(cCap),
    .chainShift(cShift), .chainUpdate(cUpd), .chainDrive(cDrive), .chainSo(cSo)
  );

  // bench model of an external boundary chain
  always @(posedge clk) begin
    if (cCap)        chainReg <= pinPattern;
    else if (cShift) chainReg <= {tdi, chainReg[CH_W-1:1]};
    if (cUpd) updCount <= updCount + 1;
  end
  assign cSo = chainReg[0];

  task automatic check(input bit ok, input string req, input logic [39:0] act, input logic [39:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  task automatic tick(input logic m, input logic d);
    tms = m; tdi = d;
    @(posedge clk); @(negedge clk); #1;
  endtask

  // from Run-Test/Idle, shift the IR; stops in Exit1-IR
  task automatic irBody(input logic [3:0] code, output logic [3:0] cap);
    tick(1, 0); tick(1, 0); tick(0, 0); tick(0, 0);
    cap[0] = tdo;
    check(tdoEn == 1'b1, "R4 enable in Shift-IR", 40'(tdoEn), 40'd1);
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, code[i]);
      if (i < 3) cap[i+1] = tdo;
    end
  endtask

  task automatic loadIr(input logic [3:0] code);
    logic [3:0] cap;
    irBody(code, cap);
    tick(1, 0); tick(0, 0);
  endtask

  task automatic shiftDr(input int n, input logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    tick(1, 0); tick(0, 0); tick(0, 0);
    dout[0] = tdo;
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      if (i < n - 1) dout[i+1] = tdo;
    end
    check(tdoEn == 1'b0, "R4 enable off after shift", 40'(tdoEn), 40'd0);
    tick(1, 0); tick(0, 0);
  endtask

  initial begin
    #(4 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [39:0] got;
    logic [3:0]  cap;
    logic [15:0] walk = 16'b0110_1001_1100_0101;

    repeat (3) tick(1, 0);
    check(tdoEn == 0 && cDrive == 0, "R3 reset state", {38'd0, tdoEn, cDrive}, 40'd0);
    trstN = 1'b1;
    tick(0, 0);

    // R7 default instruction reads the identification value, twice
    for (int r = 0; r < 2; r++) begin
      shiftDr(32, 40'hFFFF_FFFF, got);
      check(got[31:0] == EXP_ID, "R7 identification readout", got, 40'(EXP_ID));
    end
    check(EXP_ID[0] == 1'b1, "R7 id lsb", 40'(EXP_ID[0]), 40'd1);

    // R5 capture pattern
    irBody(4'b1111, cap);
    check(cap == 4'b0001, "R5 capture-IR pattern", 40'(cap), 40'd1);
    tick(1, 0); tick(0, 0);

    // R8 bypass and every unused code
    for (int c = 3; c < 16; c++) begin
      logic [7:0] pat;
      loadIr(4'(c));
      pat = 8'(c * 37 + 11);
      shiftDr(8, 40'(pat), got);
      check(got[7:0] == {pat[6:0], 1'b0}, "R8 one-bit path", got, 40'({pat[6:0], 1'b0}));
      check(cDrive == 1'b0, "R10 no drive outside external test", 40'(cDrive), 40'd0);
    end

    // R9 sample/preload through the external chain
    loadIr(4'b0001);
    updCount = 0;
    shiftDr(CH_W, 40'(6'b010011), got);
    check(got[CH_W-1:0] == pinPattern, "R9 chain capture on data out", got, 40'(pinPattern));
    check(chainReg == 6'b010011, "R9 chain shifted in", 40'(chainReg), 40'(6'b010011));
    check(updCount == 1, "R9 one update strobe", 40'(updCount), 40'd1);
    check(cDrive == 1'b0, "R10 sample does not drive", 40'(cDrive), 40'd0);

    // R6 instruction changes on the falling edge of Update-IR
    irBody(4'b0000, cap);
    tms = 1; @(posedge clk); #0.5;
    check(cDrive == 1'b0, "R6 old instruction before falling edge", 40'(cDrive), 40'd0);
    @(negedge clk); #1;
    check(cDrive == 1'b1, "R10 external test drives", 40'(cDrive), 40'd1);
    tick(0, 0);

    // R3 asynchronous reset in the middle of a shift
    tick(1, 0); tick(0, 0); tick(0, 0);
    check(tdoEn == 1'b1, "R4 enable in Shift-DR", 40'(tdoEn), 40'd1);
    trstN = 1'b0; #1;
    check(tdoEn == 0 && cDrive == 0, "R3 async reset", {38'd0, tdoEn, cDrive}, 40'd0);
    tick(1, 0); trstN = 1'b1; tick(0, 0);
    shiftDr(32, 40'd0, got);
    check(got[31:0] == EXP_ID, "R3 identification after reset", got, 40'(EXP_ID));

    // R2 R1 five high mode-select edges from many walked states
    for (int k = 0; k < 16; k++) begin
      loadIr(4'b1111);
      for (int j = 0; j < k; j++) tick(walk[j], 0);
      repeat (5) tick(1, 0);
      check(tdoEn == 1'b0, "R2 reset state output off", 40'(tdoEn), 40'd0);
      tick(0, 0);
      shiftDr(32, 40'd0, got);
      check(got[31:0] == EXP_ID, "R2 reset restores identification", got, 40'(EXP_ID));
    end

    done = 1;
    summary();
  end
endmodule